// File: doc/BRIEF.md
# Whole-Block Bitstream Packer

This block gathers variable-length codes, each given as a value and a bit count, into one wide accumulation register. Every accepted code is appended at the least-significant end, so older bits move toward the top of the register. A running total keeps track of how many valid bits the register holds. When the producer has finished a block it pulses a flush strobe. The register is then shifted left until the first bit ever written sits in its most-significant position.

After the flush the block switches to a drain phase. The top 32 bits of the register are shown on a read port together with a valid flag. Each read acknowledge moves the register up by one word. A processor reads the whole packed stream this way, most-significant bit first. The last word may hold fewer than 32 real bits, so its unused low bits read as zeros. The total-bit output stays steady for the whole drain so that software can work out how much padding to drop. Once the word holding the final bit has been acknowledged, the block clears its count and takes codes again.

The register is 1024 bits wide and codes are at most 16 bits long. Both are parameters.

Top module: `bitpack_top`

## Requirements
- R1: After reset, `bit_total` is 0, `rd_valid` is 0, and `code_ready` is 1 whenever `flush` is low.
- R2: An accepted code (`code_valid` and `code_ready` high at a clock edge) appends the low `code_len` bits of `code_bits` to the stream, most-significant of those bits first. Bits of `code_bits` at position `code_len` and above have no effect.
- R3: Each accepted code increases `bit_total` by `code_len` on the next cycle. While `rd_valid` is high, `bit_total` holds its value.
- R4: `code_ready` is low whenever `bit_total + code_len` would exceed the 1024-bit capacity. A code that exactly fills the capacity is accepted. `bit_total` never exceeds 1024.
- R5: A `flush` pulse with a nonzero `bit_total` raises `rd_valid` on the next cycle. `rd_data` then holds the first 32 stream bits, and the earliest written bit is at `rd_data[31]`.
- R6: While `rd_valid` is high, each cycle with `rd_ack` high advances `rd_data` to the next 32 stream bits. Without `rd_ack`, `rd_data` and `rd_valid` stay unchanged.
- R7: In the last word, bit positions past the end of the stream read as 0. Acknowledging the word that holds the last stream bit drops `rd_valid` and returns `bit_total` to 0 on the next cycle.
- R8: `code_ready` is low while `rd_valid` is high and while `flush` is high. `flush` has no effect during the drain phase, and it has no effect when `bit_total` is 0.
- R9: A code with `code_len` equal to 0 is accepted without changing the stream or `bit_total`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| code_valid | input | 1 | A code is offered |
| code_ready | output | 1 | The offered code fits and will be taken |
| code_bits | input | 16 | Code value, right-aligned |
| code_len | input | 5 | Number of valid code bits, 0 to 16 |
| flush | input | 1 | End of block: left-justify the register and start the drain |
| rd_data | output | 32 | Current top word of the justified stream |
| rd_valid | output | 1 | Drain phase active, `rd_data` meaningful |
| rd_ack | input | 1 | Consume the current word |
| bit_total | output | 11 | Number of stream bits accumulated |

## Verification
The assertions take for granted that `code_len` never exceeds the maximum code width. The stimulus only ever draws lengths from 0 to 16. The handshake checks also assume that inputs are steady around each clock edge. The bench meets this by changing every input on the falling edge. No assumption limits flush or acknowledge timing, so the stimulus pulses `flush` and `rd_ack` freely, including during the drain, with an empty register, and alongside offered codes. One directed run fills the capacity exactly so that the refusal boundary is exercised.

// File: rtl/bitpack_pkg.sv
package bitpack_pkg;

    typedef enum logic [0:0] {
        PH_FILL  = 1'b0,
        PH_DRAIN = 1'b1
    } phase_e;

endpackage

// File: rtl/bitpack_accum.sv
module bitpack_accum #(
    parameter int ACC_W  = 1024,
    parameter int CODE_W = 16,
    parameter int LEN_W  = 5,
    parameter int CNT_W  = 11,
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [CODE_W-1:0] push_bits,
    input  logic [LEN_W-1:0]  push_len,
    input  logic              justify,
    input  logic [CNT_W-1:0]  justify_amt,
    input  logic              pop,
    output logic [WORD_W-1:0] head_word
);

    typedef struct packed {
        logic [ACC_W-1:0] acc;
    } acc_state_t;

    acc_state_t st_d, st_q;
    logic [CODE_W-1:0] masked;

    // keep only the low push_len bits of the code
    always_comb begin
        masked = '0;
        for (int i = 0; i < CODE_W; i++) begin
            masked[i] = push_bits[i] && (i < int'(push_len));
        end
    end

    always_comb begin
        st_d = st_q;
        if (push) begin
            st_d.acc = (st_q.acc << push_len) | ACC_W'(masked);
        end else if (justify) begin
            st_d.acc = st_q.acc << justify_amt;
        end else if (pop) begin
            st_d.acc = st_q.acc << WORD_W;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign head_word = st_q.acc[ACC_W-1 -: WORD_W];

endmodule

// File: rtl/bitpack_ctrl.sv
module bitpack_ctrl
    import bitpack_pkg::*;
#(
    parameter int ACC_W  = 1024,
    parameter int LEN_W  = 5,
    parameter int CNT_W  = 11,
    parameter int WORD_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             code_valid,
    input  logic [LEN_W-1:0] code_len,
    input  logic             flush,
    input  logic             rd_ack,
    output logic             code_ready,
    output logic             push,
    output logic             justify,
    output logic [CNT_W-1:0] justify_amt,
    output logic             pop,
    output logic             rd_valid,
    output logic [CNT_W-1:0] bit_total
);

    typedef struct packed {
        phase_e           phase;
        logic [CNT_W-1:0] total;
        logic [CNT_W-1:0] left;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;
    logic [CNT_W:0] sum_len;
    logic           fits;

    assign sum_len = {1'b0, st_q.total} + (CNT_W + 1)'(code_len);
    assign fits    = (sum_len <= (CNT_W + 1)'(ACC_W));

    always_comb begin
        st_d        = st_q;
        code_ready  = (st_q.phase == PH_FILL) && !flush && fits;
        push        = code_valid && code_ready;
        justify     = 1'b0;
        justify_amt = CNT_W'(ACC_W) - st_q.total;
        pop         = 1'b0;
        if (st_q.phase == PH_FILL) begin
            if (flush && (st_q.total != '0)) begin
                justify    = 1'b1;
                st_d.phase = PH_DRAIN;
                st_d.left  = st_q.total;
            end else if (push) begin
                st_d.total = sum_len[CNT_W-1:0];
            end
        end else if (rd_ack) begin
            pop = 1'b1;
            if (st_q.left <= CNT_W'(WORD_W)) begin
                st_d.phase = PH_FILL;
                st_d.total = '0;
                st_d.left  = '0;
            end else begin
                st_d.left = st_q.left - CNT_W'(WORD_W);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_FILL, total: '0, left: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_valid  = (st_q.phase == PH_DRAIN);
    assign bit_total = st_q.total;

endmodule

// File: rtl/bitpack_top.sv
module bitpack_top #(
    parameter int ACC_W  = 1024,
    parameter int CODE_W = 16,
    parameter int WORD_W = 32,
    localparam int LEN_W = $clog2(CODE_W + 1),
    localparam int CNT_W = $clog2(ACC_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              code_valid,
    output logic              code_ready,
    input  logic [CODE_W-1:0] code_bits,
    input  logic [LEN_W-1:0]  code_len,
    input  logic              flush,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_valid,
    input  logic              rd_ack,
    output logic [CNT_W-1:0]  bit_total
);

    logic             push;
    logic             justify;
    logic [CNT_W-1:0] justify_amt;
    logic             pop;

    bitpack_ctrl #(
        .ACC_W (ACC_W),
        .LEN_W (LEN_W),
        .CNT_W (CNT_W),
        .WORD_W(WORD_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .code_valid (code_valid),
        .code_len   (code_len),
        .flush      (flush),
        .rd_ack     (rd_ack),
        .code_ready (code_ready),
        .push       (push),
        .justify    (justify),
        .justify_amt(justify_amt),
        .pop        (pop),
        .rd_valid   (rd_valid),
        .bit_total  (bit_total)
    );

    bitpack_accum #(
        .ACC_W (ACC_W),
        .CODE_W(CODE_W),
        .LEN_W (LEN_W),
        .CNT_W (CNT_W),
        .WORD_W(WORD_W)
    ) u_accum (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (push),
        .push_bits  (code_bits),
        .push_len   (code_len),
        .justify    (justify),
        .justify_amt(justify_amt),
        .pop        (pop),
        .head_word  (rd_data)
    );

endmodule

// File: rtl/bitpack_chk.sv
module bitpack_chk #(
    parameter int ACC_W  = 1024,
    parameter int CODE_W = 16,
    parameter int WORD_W = 32,
    parameter int LEN_W  = 5,
    parameter int CNT_W  = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              code_valid,
    input logic              code_ready,
    input logic [LEN_W-1:0]  code_len,
    input logic              flush,
    input logic [WORD_W-1:0] rd_data,
    input logic              rd_valid,
    input logic              rd_ack,
    input logic [CNT_W-1:0]  bit_total
);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        bit_total <= CNT_W'(ACC_W)); // R4

    AST_ACCEPT_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
        (code_valid && code_ready) |=> (bit_total == $past(bit_total) + CNT_W'($past(code_len)))); // R3

    AST_WORD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ack) |=> (rd_valid && $stable(rd_data))); // R6

    AST_NO_READY_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid || flush) |-> !code_ready); // R8

    AST_TOTAL_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> (rd_valid ? $stable(bit_total) : (bit_total == '0))); // R7

    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_valid && flush && bit_total == '0) |=> !rd_valid); // R8

endmodule

bind bitpack_top bitpack_chk #(
    .ACC_W (ACC_W),
    .CODE_W(CODE_W),
    .WORD_W(WORD_W),
    .LEN_W (LEN_W),
    .CNT_W (CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .code_valid(code_valid),
    .code_ready(code_ready),
    .code_len  (code_len),
    .flush     (flush),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid),
    .rd_ack    (rd_ack),
    .bit_total (bit_total)
);

// File: tb/bitpack_top_test.sv
module bitpack_top_test;

    localparam int CLK_PERIOD = 10;
    localparam int CAP        = 1024;
    localparam int MAX_CYC    = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        code_valid = 1'b0;
    logic        code_ready;
    logic [15:0] code_bits = '0;
    logic [4:0]  code_len = '0;
    logic        flush = 1'b0;
    logic [31:0] rd_data;
    logic        rd_valid;
    logic        rd_ack = 1'b0;
    logic [10:0] bit_total;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    bit q[$];
    int m_total = 0;
    bit m_drain = 1'b0;

    bitpack_top uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .code_valid(code_valid),
        .code_ready(code_ready),
        .code_bits (code_bits),
        .code_len  (code_len),
        .flush     (flush),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid),
        .rd_ack    (rd_ack),
        .bit_total (bit_total)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > MAX_CYC) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run exceeded %0d cycles", MAX_CYC);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // one clock: drive on falling edge, compare, advance model
    task automatic step(input bit v, input logic [15:0] b, input int len,
                        input bit fl, input bit ack, input string ph);
        bit          e_ready;
        logic [31:0] e_word;
        @(negedge clk);
        code_valid = v;
        code_bits  = b;
        code_len   = 5'(len);
        flush      = fl;
        rd_ack     = ack;
        #1;
        e_ready = !m_drain && !fl && (m_total + len <= CAP);
        e_word  = '0;
        for (int i = 0; i < 32; i++) begin
            if (i < q.size()) e_word[31-i] = q[i];
        end
        cmp({ph, " R4 R8 code_ready"}, 32'(code_ready), 32'(e_ready));
        cmp({ph, " R5 R7 rd_valid"}, 32'(rd_valid), 32'(m_drain));
        cmp({ph, " R3 R7 bit_total"}, 32'(bit_total), 32'(m_total));
        if (m_drain) cmp({ph, " R2 R5 R6 R7 rd_data"}, rd_data, e_word);
        if (!m_drain) begin
            if (fl && m_total > 0) begin
                m_drain = 1'b1;
            end else if (v && e_ready) begin
                for (int k = len - 1; k >= 0; k--) q.push_back(b[k]);
                m_total += len;
            end
        end else if (ack) begin
            for (int k = 0; k < 32; k++) begin
                if (q.size() > 0) void'(q.pop_front());
            end
            if (q.size() == 0) begin
                m_drain = 1'b0;
                m_total = 0;
            end
        end
    endtask

    task automatic drain(input int gap, input string ph);
        int g = 0;
        while (m_drain) begin
            step(1'b1, 16'hffff, 3, (g % 3) == 1, (g % (gap + 1)) == 0, ph);
            g++;
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        step(1'b0, '0, 0, 1'b0, 1'b0, "R1");

        // R2 R9 directed codes with junk above the length
        step(1'b1, 16'hfe01 | 16'h01c1, 9, 1'b0, 1'b0, "R2");
        step(1'b1, 16'hffa6, 6, 1'b0, 1'b0, "R2");
        step(1'b1, 16'hffff, 0, 1'b0, 1'b0, "R9");
        step(1'b1, 16'h1234, 16, 1'b0, 1'b0, "R2");
        step(1'b1, 16'h0001, 1, 1'b0, 1'b0, "R2");
        step(1'b1, 16'h4567, 16, 1'b0, 1'b1, "R2");
        step(1'b0, '0, 0, 1'b1, 1'b0, "R5");
        drain(2, "R6");

        // R8 flush with empty register
        step(1'b0, '0, 0, 1'b1, 1'b0, "R8");
        step(1'b0, '0, 0, 1'b0, 1'b0, "R8");

        // R4 exact fill, then refusal
        for (int i = 0; i < 64; i++) step(1'b1, 16'(16'h8001 + i * 16'h0303), 16, 1'b0, 1'b0, "R4");
        step(1'b1, 16'h0001, 1, 1'b0, 1'b0, "R4");
        step(1'b1, 16'h0000, 0, 1'b0, 1'b0, "R9");
        step(1'b0, '0, 0, 1'b1, 1'b0, "R5");
        drain(1, "R8");

        // R7 exact word multiple and a single bit
        step(1'b1, 16'hffff, 16, 1'b0, 1'b0, "R7");
        step(1'b1, 16'h8000, 16, 1'b0, 1'b0, "R7");
        step(1'b0, '0, 0, 1'b1, 1'b0, "R7");
        drain(0, "R7");
        step(1'b1, 16'h0003, 1, 1'b0, 1'b0, "R7");
        step(1'b0, '0, 0, 1'b1, 1'b0, "R7");
        drain(3, "R7");

        // random traffic
        for (int i = 0; i < 6000; i++) begin
            step(($urandom % 4) != 0, 16'($urandom), int'($urandom % 17),
                 ($urandom % 90) == 0, ($urandom % 2) == 0, "R2 R6 random");
        end
        step(1'b0, '0, 0, 1'b1, 1'b0, "R5");
        drain(1, "R6");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule